// File: doc/BRIEF.md
# Keyed Power-Domain Turn-On Sequencer

This block is a small memory-mapped controller that brings power domains up on request from software. Software picks the domains to switch on by writing a one-hot mask into a turn-on mode register. It then writes a three-byte unlock key into a trigger register. Only a complete key, written in the right order, launches a power-up. Once launched, the controller raises the enable output of every selected domain and runs a programmable settle counter. A domain's bit then appears in the read-only power status register when two things hold: the settle counter has run out, and that domain's power-good input is high.

The register bus is a plain single-cycle interface: an address, a write strobe, write data, and read data that follows the address combinationally. While a power-up is in progress, a busy flag reads as 1 and further key sequences are ignored. Domains 0 and 1 are on out of reset. There is no turn-off path, so status bits only ever get added.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the status register (offset 0x80) reads 0x00000003, the mode register (offset 0x0C) reads 0, and the domain enable outputs equal 0x03.
- R2: A write to offset 0x0C stores the low NUM_DOM bits of the write data as the turn-on mask, and a read of 0x0C returns that mask zero-extended.
- R3: Writing the bytes 0xFF, 0x05 and 0x50 (write data bits 7:0) to offset 0x44 as three successive trigger writes starts a power-up. From the clock edge of the last of these writes, busy is 1 and the enable outputs include every bit of the mask.
- R4: A trigger write that breaks the key order returns the matcher to its start, except that a wrong byte of 0xFF counts as the first key byte. Writes to other offsets between key bytes do not disturb the matcher.
- R5: With power-good high, a requested domain's status bit sets at exactly the SETTLE_CYCLES-th clock edge after the edge of the final key write, and not before.
- R6: A requested domain's status bit waits for its power-good input. Busy stays 1 until every requested domain reports good, and it clears on the edge that sets the last bit.
- R7: Bit 31 of offset 0x80 reads 1 while a power-up is in progress. Trigger writes made during that time start nothing, and the mask is captured only at start.
- R8: Writes to offset 0x80 have no effect. Reads of the trigger offset and of any unmapped offset return zero.
- R9: Status bits never clear once set, and a status bit is never set without the matching enable output being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dom_pwr_en | output | NUM_DOM | Per-domain power switch enable |
| dom_pwr_good | input | NUM_DOM | Per-domain power-good indication |

## Verification
A key matcher stuck in the wrong step shows in one of two ways. Either a broken sequence raises bit 31 of the status read at the very next sample, or a valid key fails to raise it. A settle counter loaded with the wrong value moves the status change off its exact edge, so the bench samples the cycle just before and the cycle exactly at SETTLE_CYCLES. A lost or stale enable capture shows on the enable outputs as soon as the final key edge has passed, and a leaked late request shows as extra status bits once the settle time has expired.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam logic [7:0] KEY_BYTE0 = 8'hFF;
  localparam logic [7:0] KEY_BYTE1 = 8'h05;
  localparam logic [7:0] KEY_BYTE2 = 8'h50;

  localparam int unsigned OFS_MODE   = 32'h0C;
  localparam int unsigned OFS_TRIG   = 32'h44;
  localparam int unsigned OFS_STATUS = 32'h80;

  localparam int unsigned BUSY_BIT = 31;

  typedef enum logic [1:0] {
    KEY_WAIT0 = 2'd0,
    KEY_WAIT1 = 2'd1,
    KEY_WAIT2 = 2'd2
  } key_step_e;

endpackage

// File: rtl/pwr_key_matcher.sv
module pwr_key_matcher
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_wr,
  input  logic [7:0] trig_byte,
  input  logic       lock,
  output logic       key_fire
);

  key_step_e step_q, step_d;
  logic      fire_d;

  always_comb begin
    step_d = step_q;
    fire_d = 1'b0;
    if (lock) begin
      step_d = KEY_WAIT0;
    end else if (trig_wr) begin
      unique case (step_q)
        KEY_WAIT0: step_d = (trig_byte == KEY_BYTE0) ? KEY_WAIT1 : KEY_WAIT0;
        KEY_WAIT1: begin
          if (trig_byte == KEY_BYTE1)      step_d = KEY_WAIT2;
          else if (trig_byte == KEY_BYTE0) step_d = KEY_WAIT1;
          else                             step_d = KEY_WAIT0;
        end
        KEY_WAIT2: begin
          if (trig_byte == KEY_BYTE2) begin
            step_d = KEY_WAIT0;
            fire_d = 1'b1;
          end else if (trig_byte == KEY_BYTE0) begin
            step_d = KEY_WAIT1;
          end else begin
            step_d = KEY_WAIT0;
          end
        end
        default: step_d = KEY_WAIT0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= KEY_WAIT0;
    else        step_q <= step_d;
  end

  assign key_fire = fire_d;

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic finish,
  output logic busy,
  output logic expired
);

  localparam int unsigned CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  assign expired = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (expired && finish) begin
      busy_d = 1'b0;
    end else if (busy_q && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = start || busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/pwr_domain_state.sv
module pwr_domain_state #(
  parameter int unsigned          NUM_DOM    = 8,
  parameter logic [NUM_DOM-1:0]   RESET_MASK = NUM_DOM'(3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NUM_DOM-1:0] start_mask,
  input  logic               expired,
  input  logic [NUM_DOM-1:0] pwr_good,
  output logic [NUM_DOM-1:0] en_q,
  output logic [NUM_DOM-1:0] status_q,
  output logic               all_up
);

  logic [NUM_DOM-1:0] en_d, status_d;

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    assign en_d[i]     = en_q[i] | (start & start_mask[i]);
    assign status_d[i] = status_q[i] | (expired & en_q[i] & pwr_good[i]);
  end

  assign all_up = ((status_d & en_q) == en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= RESET_MASK;
      status_q <= RESET_MASK;
    end else begin
      if (start)   en_q     <= en_d;
      if (expired) status_q <= status_d;
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned        ADDR_W        = 8,
  parameter int unsigned        NUM_DOM       = 8,
  parameter int unsigned        SETTLE_CYCLES = 64,
  parameter logic [NUM_DOM-1:0] RESET_ON_MASK = NUM_DOM'(3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_DOM-1:0] dom_pwr_en,
  input  logic [NUM_DOM-1:0] dom_pwr_good
);

  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_TRIG   = ADDR_W'(OFS_TRIG);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  logic               mode_wr, trig_wr;
  logic [NUM_DOM-1:0] mode_q;
  logic               key_fire;
  logic               busy, settle_done, all_up;
  logic [NUM_DOM-1:0] status_q;

  assign mode_wr = bus_we && (bus_addr == A_MODE);
  assign trig_wr = bus_we && (bus_addr == A_TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= bus_wdata[NUM_DOM-1:0];
  end

  pwr_key_matcher u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_wr   (trig_wr),
    .trig_byte (bus_wdata[7:0]),
    .lock      (busy),
    .key_fire  (key_fire)
  );

  pwr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (key_fire),
    .finish  (all_up),
    .busy    (busy),
    .expired (settle_done)
  );

  pwr_domain_state #(.NUM_DOM(NUM_DOM), .RESET_MASK(RESET_ON_MASK)) u_dom (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (key_fire),
    .start_mask (mode_q),
    .expired    (settle_done),
    .pwr_good   (dom_pwr_good),
    .en_q       (dom_pwr_en),
    .status_q   (status_q),
    .all_up     (all_up)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MODE) begin
      bus_rdata = 32'(mode_q);
    end else if (bus_addr == A_STATUS) begin
      bus_rdata           = 32'(status_q);
      bus_rdata[BUSY_BIT] = busy;
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int unsigned NUM_DOM = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fire,
  input logic               busy,
  input logic               expired,
  input logic [NUM_DOM-1:0] status,
  input logic [NUM_DOM-1:0] en,
  input logic [NUM_DOM-1:0] good
);

  assert_fire_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy);

  assert_no_fire_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire);

  assert_status_held_in_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !expired |=> $stable(status));

  assert_status_needs_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(good)) == '0));

  assert_status_never_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status)) == $past(status)));

  assert_status_within_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~en) == '0);

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_DOM(NUM_DOM)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fire    (key_fire),
  .busy    (busy),
  .expired (settle_done),
  .status  (status_q),
  .en      (dom_pwr_en),
  .good    (dom_pwr_good)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int NUM_DOM    = 8;
  localparam int SETTLE     = 20;

  logic               clk;
  logic               rst_n;
  logic [ADDR_W-1:0]  bus_addr;
  logic               bus_we;
  logic [31:0]        bus_wdata;
  logic [31:0]        bus_rdata;
  logic [NUM_DOM-1:0] dom_pwr_en;
  logic [NUM_DOM-1:0] dom_pwr_good;

  pwr_seq_ctrl #(
    .ADDR_W(ADDR_W), .NUM_DOM(NUM_DOM), .SETTLE_CYCLES(SETTLE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dom_pwr_en(dom_pwr_en), .dom_pwr_good(dom_pwr_good)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_en;
    logic [31:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  chk_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = exp_q.pop_front();
        act = it.is_en ? 32'(dom_pwr_en) : bus_rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: %s addr=%h actual=%h expected=%h",
                   it.tag, it.is_en ? "pwr_en" : "read", it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    bus_addr = a[ADDR_W-1:0];
    exp_q.push_back('{1'b0, a, e, tag});
    ->chk_ev;
    #2;
  endtask

  task automatic chk_en(input logic [31:0] e, input string tag);
    exp_q.push_back('{1'b1, 32'h0, e, tag});
    ->chk_ev;
    #2;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a[ADDR_W-1:0];
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic key();
    wr(32'h44, 32'hFF);
    wr(32'h44, 32'h05);
    wr(32'h44, 32'h50);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    bus_we       = 1'b0;
    bus_addr     = '0;
    bus_wdata    = '0;
    dom_pwr_good = 8'h7F;
    idle(4);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    chk_rd(32'h80, 32'h0000_0003, "R1");
    chk_rd(32'h0C, 32'h0, "R1");
    chk_en(32'h03, "R1");

    // R8 unmapped and trigger read zero, status write ignored
    chk_rd(32'h10, 32'h0, "R8");
    chk_rd(32'h44, 32'h0, "R8");
    wr(32'h80, 32'hFFFF_FFFF);
    chk_rd(32'h80, 32'h0000_0003, "R8");

    // R2 mode write/readback
    wr(32'h0C, 32'h0000_0010);
    chk_rd(32'h0C, 32'h10, "R2");

    // R4 broken sequences start nothing
    wr(32'h44, 32'hFF); wr(32'h44, 32'h05); wr(32'h44, 32'h51); wr(32'h44, 32'h50);
    chk_rd(32'h80, 32'h0000_0003, "R4");
    wr(32'h44, 32'h05); wr(32'h44, 32'h50);
    chk_rd(32'h80, 32'h0000_0003, "R4");
    chk_en(32'h03, "R4");

    // R4 repeated 0xFF restarts at step two; unrelated write in between
    wr(32'h44, 32'hFF);
    wr(32'h44, 32'hFF);
    wr(32'h20, 32'h0);
    wr(32'h44, 32'h05);
    wr(32'h44, 32'h50);
    // R3 / R7: busy and enable right after the final key edge
    chk_rd(32'h80, 32'h8000_0003, "R3");
    chk_en(32'h13, "R3");
    // R5: unchanged one edge before the settle point, set exactly at it
    idle(SETTLE - 1);
    chk_rd(32'h80, 32'h8000_0003, "R5");
    idle(1);
    chk_rd(32'h80, 32'h0000_0013, "R5");

    // R7 key during busy is ignored, mask captured at start
    wr(32'h0C, 32'h20);
    key();
    chk_rd(32'h80, 32'h8000_0013, "R7");
    wr(32'h0C, 32'h40);
    key();
    idle(SETTLE + 10);
    chk_rd(32'h80, 32'h0000_0033, "R7");
    chk_en(32'h33, "R7");

    // R6 wait for power-good
    wr(32'h0C, 32'h80);
    key();
    idle(SETTLE + 10);
    chk_rd(32'h80, 32'h8000_0033, "R6");
    chk_en(32'hB3, "R6");
    dom_pwr_good = 8'hFF;
    idle(1);
    chk_rd(32'h80, 32'h0000_00B3, "R6");

    // R9 earlier bits still present, enables cover status
    chk_en(32'hB3, "R9");
    chk_rd(32'h0C, 32'h80, "R2");

    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule